// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Controller

This block configures a one-to-ten clock fanout. Three serial programming inputs (shift clock, serial data and an active-high enable) are sampled in the system clock domain. While the enable is high, each rising shift-clock edge moves one data bit into an eleven-bit shift register. A pulse counter tracks these edges. The twelfth edge copies the whole shift register into the control register in a single write.

The control register holds ten per-output enable bits and one source-select bit. The select bit steers one of two clock inputs, `clk_a_i` or `clk_b_i`, to every enabled output. Each output also has a tri-state flag that an I/O cell can use. A disabled output has its flag at 0 and drives 0 in place of a high-impedance level. Partial frames are discarded. Extra edges after a complete frame are ignored until the enable has been dropped and raised again.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: After reset every output enable flag is 0, every output is 0, and the source select is 0 (`clk_a_i`).
- R2: A frame is eleven data bits followed by a twelfth edge that applies them. The bit shifted in on edge k (k = 1..10) becomes the enable of output k-1. A 1 enables the output and a 0 disables it.
- R3: The bit shifted in on edge 11 is the source select. A 0 routes `clk_a_i` and a 1 routes `clk_b_i` to every enabled output.
- R4: An enabled output equals the selected clock input. A disabled output has its flag `fan_oe_o[i]` at 0 and drives 0.
- R5: The control register does not change before the twelfth edge of a frame. After eleven edges the previous configuration is still in force.
- R6: Driving the enable low clears the edge count. A partial frame never updates the control register, and the next frame starts again at output 0.
- R7: Edges after the twelfth, while the enable stays high, have no effect until the enable is dropped and raised again.
- R8: Shift-clock edges while the enable is low have no effect.
- R9: All eleven configuration bits change together in one system-clock cycle, and only on a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the programming inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial configuration data |
| sen_i | input | 1 | Active-high programming enable |
| clk_a_i | input | 1 | Clock source selected by select bit 0 |
| clk_b_i | input | 1 | Clock source selected by select bit 1 |
| fan_o | output | 10 | Gated fanout clock outputs |
| fan_oe_o | output | 10 | Per-output drive flags (0 = high impedance) |
| src_sel_o | output | 1 | Active source select |

## Verification
The hardest situation to reach from the ports is a shift register that is fully loaded but whose contents have not been applied. For that, exactly eleven edges are sent and the configuration is checked before the enable falls. A stray twelfth edge or a counter that survives the enable drop would then show up as a wrong configuration. The stimulus follows such a partial frame with a complete frame of a different pattern, which proves that the count starts again from zero. A further case sends a second full frame's worth of edges after a transfer without releasing the enable. That case exposes a counter that wraps instead of saturating.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;
  localparam int unsigned NUM_OUT    = 10;
  localparam int unsigned FRAME_LEN  = NUM_OUT + 1;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_DONE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fo_sync.sv
module fo_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fo_ser_seq.sv
module fo_ser_seq
  import clk_fanout_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_LEN,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_s_i,
  input  logic                  sdata_s_i,
  input  logic                  sen_s_i,
  output logic                  rise_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [FRAME_BITS-1:0] shreg_o,
  output logic                  load_o
);
  localparam logic [CNT_W-1:0] LOAD_AT = CNT_W'(FRAME_BITS);

  logic                  sclk_d;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] shreg_q;
  seq_state_e            state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else sclk_d <= sclk_s_i;
  end

  assign rise_o = sclk_s_i & ~sclk_d;

  always_comb begin
    if (!sen_s_i)              state = SEQ_IDLE;
    else if (cnt_q > LOAD_AT)  state = SEQ_DONE;
    else                       state = SEQ_SHIFT;
  end

  // first bit shifted lands at index 0 after a full frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE:  cnt_q <= '0;
        SEQ_SHIFT: if (rise_o) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < LOAD_AT) shreg_q <= {sdata_s_i, shreg_q[FRAME_BITS-1:1]};
        end
        SEQ_DONE:  cnt_q <= cnt_q;
        default:   cnt_q <= '0;
      endcase
    end
  end

  assign load_o  = (state == SEQ_SHIFT) && rise_o && (cnt_q == LOAD_AT);
  assign cnt_o   = cnt_q;
  assign shreg_o = shreg_q;
endmodule

// File: rtl/fo_cfg_reg.sv
module fo_cfg_reg #(
  parameter int unsigned N_OUT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N_OUT:0]   word_i,
  output logic [N_OUT-1:0] oe_o,
  output logic             sel_o
);
  logic [N_OUT:0] cfg_q;

  // whole word written at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (load_i) cfg_q <= word_i;
  end

  assign oe_o  = cfg_q[N_OUT-1:0];
  assign sel_o = cfg_q[N_OUT];
endmodule

// File: rtl/fo_out_stage.sv
module fo_out_stage #(
  parameter int unsigned N_OUT = 10
) (
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  input  logic             sel_i,
  input  logic [N_OUT-1:0] oe_i,
  output logic [N_OUT-1:0] fan_o,
  output logic [N_OUT-1:0] fan_oe_o
);
  logic src_clk;

  assign src_clk = sel_i ? clk_b_i : clk_a_i;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign fan_o[i]    = oe_i[i] & src_clk;
    assign fan_oe_o[i] = oe_i[i];
  end
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
  import clk_fanout_pkg::*;
#(
  parameter int unsigned N_OUT       = NUM_OUT,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH,
  localparam int unsigned FRAME_BITS = N_OUT + 1,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             sen_i,
  input  logic             clk_a_i,
  input  logic             clk_b_i,
  output logic [N_OUT-1:0] fan_o,
  output logic [N_OUT-1:0] fan_oe_o,
  output logic             src_sel_o
);
  logic                  sclk_s, sdata_s, sen_s;
  logic                  sclk_rise;
  logic [CNT_W-1:0]      seq_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  cfg_load;
  logic [N_OUT-1:0]      oe;
  logic                  sel;

  fo_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, sdata_i, sen_i}),
    .q_o    ({sclk_s, sdata_s, sen_s})
  );

  fo_ser_seq #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sclk_s),
    .sdata_s_i (sdata_s),
    .sen_s_i   (sen_s),
    .rise_o    (sclk_rise),
    .cnt_o     (seq_cnt),
    .shreg_o   (shreg),
    .load_o    (cfg_load)
  );

  fo_cfg_reg #(.N_OUT(N_OUT)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load),
    .word_i (shreg),
    .oe_o   (oe),
    .sel_o  (sel)
  );

  fo_out_stage #(.N_OUT(N_OUT)) i_out (
    .clk_a_i  (clk_a_i),
    .clk_b_i  (clk_b_i),
    .sel_i    (sel),
    .oe_i     (oe),
    .fan_o    (fan_o),
    .fan_oe_o (fan_oe_o)
  );

  assign src_sel_o = sel;
endmodule

// File: rtl/clk_fanout_chk.sv
module clk_fanout_chk #(
  parameter int unsigned N_OUT      = 10,
  parameter int unsigned FRAME_BITS = N_OUT + 1,
  parameter int unsigned CNT_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sen_s,
  input logic             sclk_rise,
  input logic [CNT_W-1:0] seq_cnt,
  input logic             cfg_load,
  input logic             clk_a_i,
  input logic             clk_b_i,
  input logic [N_OUT-1:0] fan_o,
  input logic [N_OUT-1:0] fan_oe_o,
  input logic             src_sel_o
);
  localparam logic [CNT_W-1:0] LOAD_AT = CNT_W'(FRAME_BITS);

  assert_load_at_frame_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load |-> (seq_cnt == LOAD_AT) && sen_s && sclk_rise);

  assert_cnt_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_s |=> (seq_cnt == '0));

  assert_cnt_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_cnt <= LOAD_AT + 1'b1);

  assert_no_load_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_s |-> !cfg_load);

  assert_cfg_atomic_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load |=> $stable({src_sel_o, fan_oe_o}));

  assert_disabled_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fan_o & ~fan_oe_o) == '0);

  assert_enabled_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fan_o & fan_oe_o) == (fan_oe_o & {N_OUT{src_sel_o ? clk_b_i : clk_a_i}}));
endmodule

bind clk_fanout_ctrl clk_fanout_chk #(
  .N_OUT(N_OUT), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sen_s     (sen_s),
  .sclk_rise (sclk_rise),
  .seq_cnt   (seq_cnt),
  .cfg_load  (cfg_load),
  .clk_a_i   (clk_a_i),
  .clk_b_i   (clk_b_i),
  .fan_o     (fan_o),
  .fan_oe_o  (fan_oe_o),
  .src_sel_o (src_sel_o)
);

// File: tb/test_clk_fanout_ctrl.sv
`timescale 1ns/1ps
module test_clk_fanout_ctrl;
  localparam int N = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic [N-1:0] fan, fan_oe;
  logic src_sel;

  int checks = 0, errors = 0;
  int pushed = 0, done_cnt = 0;
  bit finished = 0;

  logic [N:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  clk_fanout_ctrl i_clk_fanout_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sen_i(sen),
    .clk_a_i(clk_a), .clk_b_i(clk_b), .fan_o(fan), .fan_oe_o(fan_oe), .src_sel_o(src_sel)
  );

  // free-running source clocks with different periods, driven away from clk edges
  initial forever begin repeat (3) @(negedge clk); clk_a = ~clk_a; end
  initial forever begin repeat (7) @(negedge clk); clk_b = ~clk_b; end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic expect_cfg(input logic [N-1:0] oe, input logic sel, input string tag);
    exp_q.push_back({sel, oe});
    tag_q.push_back(tag);
    pushed++;
    wait (done_cnt == pushed);
  endtask

  // monitor: pops expected configuration, compares flags, select and gated clocks
  initial forever begin
    logic [N:0] e;
    string t;
    int bad;
    logic [N-1:0] exp_fan;
    wait (exp_q.size() != 0);
    repeat (10) @(negedge clk);
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if ({src_sel, fan_oe} !== e) begin
      errors++;
      $display("FAIL %s config: got sel=%b oe=%b expected sel=%b oe=%b",
               t, src_sel, fan_oe, e[N], e[N-1:0]);
    end
    bad = 0;
    exp_fan = '0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      exp_fan = e[N-1:0] & {N{e[N] ? clk_b : clk_a}};
      if (fan !== exp_fan && bad == 0) begin
        bad = 1;
        $display("FAIL R4 (%s) outputs: got %b expected %b", t, fan, exp_fan);
      end
    end
    checks++;
    if (bad != 0) errors++;
    done_cnt++;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_bit(input logic b);
    sdata = b; hold(6);
    sclk = 1'b1; hold(6);
    sclk = 1'b0; hold(2);
  endtask

  // bits[k] is shifted on edge k+1; edges beyond eleven send 0
  task automatic send_edges(input logic [N:0] bits, input int n_edges);
    for (int k = 0; k < n_edges; k++) edge_bit(k <= N ? bits[k] : 1'b0);
  endtask

  task automatic enable(input logic v);
    sen = v; hold(6);
  endtask

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(2);
    // R1 reset state
    expect_cfg('0, 1'b0, "R1 reset");

    // R2 bit order: edge1 -> out0, edge10 -> out9, select 0
    enable(1'b1);
    send_edges({1'b0, 10'b1000000101}, 12);
    enable(1'b0);
    expect_cfg(10'b1000000101, 1'b0, "R2 order");

    // R3 select clk_b with all outputs on
    enable(1'b1);
    send_edges({1'b1, 10'h3FF}, 12);
    enable(1'b0);
    expect_cfg(10'h3FF, 1'b1, "R3 select_b");

    // R5 eleven edges only: old config remains
    enable(1'b1);
    send_edges({1'b0, 10'h0F0}, 11);
    expect_cfg(10'h3FF, 1'b1, "R5 partial");
    // R6 drop enable, then full new frame realigns to output 0
    enable(1'b0);
    expect_cfg(10'h3FF, 1'b1, "R6 discard");
    enable(1'b1);
    send_edges({1'b0, 10'h2AA}, 12);
    expect_cfg(10'h2AA, 1'b0, "R6 realign");

    // R7 extra edges with enable held high are ignored
    send_edges({1'b1, 10'h155}, 12);
    expect_cfg(10'h2AA, 1'b0, "R7 extra");
    enable(1'b0);

    // R8 edges with enable low are ignored
    send_edges({1'b1, 10'h0FF}, 12);
    expect_cfg(10'h2AA, 1'b0, "R8 disabled");

    // R9 full word swap in one transfer
    enable(1'b1);
    send_edges({1'b1, 10'h155}, 12);
    enable(1'b0);
    expect_cfg(10'h155, 1'b1, "R9 swap");

    // R3 back to clk_a, R4 all disabled
    enable(1'b1);
    send_edges({1'b0, 10'h000}, 12);
    enable(1'b0);
    expect_cfg(10'h000, 1'b0, "R4 all_off");

    enable(1'b1);
    send_edges({1'b0, 10'h201}, 12);
    enable(1'b0);
    expect_cfg(10'h201, 1'b0, "R3 select_a");

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule